// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers sixteen interrupt lines, holds a pending flag per line, and presents the lowest-numbered line that is both pending and allowed to the processor as an index. Lines 0 to 3 are fixed and always allowed. Line 0 is the reset event, line 1 the non-maskable pin and lines 2 and 3 reserved fixed inputs. Lines 4 to 15 are maskable. Each takes its source from a pool of sixteen events (four qualified external pins and twelve peripheral events), chosen by a per-line selector register.

A line is allowed only while its enable bit and the global enable are both set. When the processor acknowledges the presented interrupt, its flag is cleared and the global enable is saved into a previous-enable bit and then cleared. A return strobe restores it from that bit. External pins and the non-maskable pin pass through pulse-width qualifiers, so glitches shorter than the minimum never reach a flag.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all flags, enable bits, the global enable and the saved enable read 0, and the irq output is low. The selector of line k reads k-4. Register addresses are: 0 flags (read), 1 clear (write), 2 enables, 3 status (bit 0 global enable, bit 1 saved enable), and 16+k the selector of line k (k = 4..15).
- R2: A flag bit is set at the clock edge where the line's source is 1 and was 0 at the previous edge. A source held high sets the flag only once.
- R3: The qualified level of an external pin changes only after the pin has held the opposite value at 4 consecutive clock edges. Its rising qualified level sets the flag of the line that selects it one edge later. Shorter high or low pulses have no effect.
- R4: The non-maskable pin (line 1) is qualified in the same way with a minimum of 2 edges.
- R5: When several allowed flags are pending, vec_o carries the lowest index and irq_o is high.
- R6: Lines 4 to 15 are presented only when both their enable bit and the global enable are 1. Lines 0 to 3 ignore both, and enable bits 3:0 always read as 1.
- R7: An acknowledge while irq_o is high clears the flag at vec_o, copies the global enable into the saved enable and clears the global enable. An acknowledge while irq_o is low has no effect.
- R8: A return strobe (with no acknowledge taken) copies the saved enable into the global enable.
- R9: A write to address 1 clears every flag whose data bit is 1.
- R10: The selector value s of line k picks pool source s. Values 0..3 are external pins 0..3 and values 4..15 are peripheral events 0..11. A source that no line selects sets no flag.
- R11: A new rising edge on a line beats an acknowledge or software clear of the same flag in the same cycle. An acknowledge beats a return strobe and a status write in the same cycle, and a return strobe beats a status write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rst_evt_i | input | 1 | Reset event source for line 0 |
| nmi_pin_i | input | 1 | Non-maskable pin, line 1 |
| rsv_irq_i | input | 2 | Reserved fixed sources, lines 2 and 3 |
| ext_pin_i | input | 4 | External interrupt pins (pool 0..3) |
| per_evt_i | input | 12 | Peripheral events (pool 4..15) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| ack_i | input | 1 | Processor acknowledge of the presented interrupt |
| rti_i | input | 1 | Return-from-interrupt strobe |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | 4 | Index of the presented line |

## Verification
The acknowledge that clears a flag can arrive in the same cycle as a fresh rising edge on that line, and a software clear can meet an edge in the same way. Acknowledge, return and status write can also compete for the global enable. The bench drives those inputs together on one edge. It then judges the outcome by reading back the flag and status registers and by comparing irq_o and vec_o on every clock against a behavioural model that applies the stated precedence.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NUM_LINES = 16;
  localparam int NUM_FIXED = 4;
  localparam int NUM_EXT   = 4;
  localparam int NUM_PER   = 12;
  localparam int NUM_SRC   = NUM_EXT + NUM_PER;
  localparam int SEL_W     = $clog2(NUM_SRC);
  localparam int VEC_W     = $clog2(NUM_LINES);
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 32;
  localparam int EXT_MIN   = 4;
  localparam int NMI_MIN   = 2;
  localparam int SEL_BASE  = 16;

  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(3);
endpackage

// File: rtl/pic_pulse_qual.sv
module pic_pulse_qual #(
  parameter int MIN_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic lvl_o
);
  localparam int CNT_W = $clog2(MIN_W + 1);

  logic             lvl_q;
  logic [CNT_W-1:0] cnt_q;

  // level flips only after MIN_W consecutive samples of the opposite value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (pin_i == lvl_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_W'(MIN_W - 1)) begin
      lvl_q <= pin_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign lvl_o = lvl_q;

  AST_QUAL_FOLLOWS_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(pin_i))); // R3
endmodule

// File: rtl/pic_src_sel.sv
module pic_src_sel #(
  parameter int NUM_SRC  = 16,
  parameter int NUM_SLOT = 12,
  parameter int SEL_W    = 4
) (
  input  logic [NUM_SRC-1:0]              pool_i,
  input  logic [NUM_SLOT-1:0][SEL_W-1:0]  sel_i,
  output logic [NUM_SLOT-1:0]             src_o
);
  for (genvar k = 0; k < NUM_SLOT; k++) begin : g_slot
    assign src_o[k] = (int'(sel_i[k]) < NUM_SRC) ? pool_i[sel_i[k]] : 1'b0;
  end
endmodule

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
  parameter int N     = 16,
  parameter int VEC_W = 4
) (
  input  logic [N-1:0]     pend_i,
  output logic             any_o,
  output logic [VEC_W-1:0] vec_o
);
  always_comb begin
    any_o = 1'b0;
    vec_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        any_o = 1'b1;
        vec_o = i[VEC_W-1:0];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int EXT_MIN_W = EXT_MIN,
  parameter int NMI_MIN_W = NMI_MIN
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rst_evt_i,
  input  logic                 nmi_pin_i,
  input  logic [NUM_FIXED-3:0] rsv_irq_i,
  input  logic [NUM_EXT-1:0]   ext_pin_i,
  input  logic [NUM_PER-1:0]   per_evt_i,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  input  logic                 ack_i,
  input  logic                 rti_i,
  output logic                 irq_o,
  output logic [VEC_W-1:0]     vec_o
);
  localparam int NUM_MASK = NUM_LINES - NUM_FIXED;

  logic [NUM_EXT-1:0]                  ext_lvl;
  logic                                nmi_lvl;
  logic [NUM_SRC-1:0]                  pool;
  logic [NUM_MASK-1:0]                 slot_src;
  logic [NUM_LINES-1:0]                line_src, src_prev_q, set_vec;
  logic [NUM_LINES-1:0]                flag_q, ack_clr, sw_clr, pend;
  logic [NUM_LINES-1:NUM_FIXED]        ien_q;
  logic [NUM_MASK-1:0][SEL_W-1:0]      sel_q;
  logic                                gie_q, pgie_q;
  logic                                irq, take;
  logic [VEC_W-1:0]                    vec;

  // pin conditioning
  for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext_qual
    pic_pulse_qual #(.MIN_W(EXT_MIN_W)) u_qual (
      .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(ext_pin_i[i]), .lvl_o(ext_lvl[i])
    );
  end

  pic_pulse_qual #(.MIN_W(NMI_MIN_W)) u_nmi_qual (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(nmi_pin_i), .lvl_o(nmi_lvl)
  );

  assign pool = {per_evt_i, ext_lvl};

  pic_src_sel #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_MASK), .SEL_W(SEL_W)) u_sel (
    .pool_i(pool), .sel_i(sel_q), .src_o(slot_src)
  );

  assign line_src = {slot_src, rsv_irq_i, nmi_lvl, rst_evt_i};
  assign set_vec  = line_src & ~src_prev_q;

  // selector registers, one per maskable line
  for (genvar k = 0; k < NUM_MASK; k++) begin : g_sel_reg
    logic wr_sel;
    assign wr_sel = reg_we_i && (reg_addr_i == ADDR_W'(SEL_BASE + NUM_FIXED + k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sel_q[k] <= SEL_W'(k);
      else if (wr_sel) sel_q[k] <= reg_wdata_i[SEL_W-1:0];
    end
  end

  // presentation
  assign pend = flag_q & {ien_q & {NUM_MASK{gie_q}}, {NUM_FIXED{1'b1}}};

  pic_prio_enc #(.N(NUM_LINES), .VEC_W(VEC_W)) u_enc (
    .pend_i(pend), .any_o(irq), .vec_o(vec)
  );

  assign irq_o   = irq;
  assign vec_o   = vec;
  assign take    = ack_i && irq;
  assign ack_clr = take ? (NUM_LINES'(1) << vec) : '0;
  assign sw_clr  = (reg_we_i && reg_addr_i == A_CLR) ? reg_wdata_i[NUM_LINES-1:0] : '0;

  // flags: a new edge wins over any clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q     <= '0;
      src_prev_q <= '0;
    end else begin
      flag_q     <= (flag_q & ~(ack_clr | sw_clr)) | set_vec;
      src_prev_q <= line_src;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               ien_q <= '0;
    else if (reg_we_i && reg_addr_i == A_IEN)  ien_q <= reg_wdata_i[NUM_LINES-1:NUM_FIXED];
  end

  // global enable: ack > return > status write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q  <= 1'b0;
      pgie_q <= 1'b0;
    end else if (take) begin
      pgie_q <= gie_q;
      gie_q  <= 1'b0;
    end else if (rti_i) begin
      gie_q  <= pgie_q;
    end else if (reg_we_i && reg_addr_i == A_STAT) begin
      gie_q  <= reg_wdata_i[0];
      pgie_q <= reg_wdata_i[1];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == A_FLAG) reg_rdata_o[NUM_LINES-1:0] = flag_q;
    if (reg_addr_i == A_IEN)  reg_rdata_o[NUM_LINES-1:0] = {ien_q, {NUM_FIXED{1'b1}}};
    if (reg_addr_i == A_STAT) reg_rdata_o[1:0] = {pgie_q, gie_q};
    for (int k = 0; k < NUM_MASK; k++) begin
      if (reg_addr_i == ADDR_W'(SEL_BASE + NUM_FIXED + k)) reg_rdata_o[SEL_W-1:0] = sel_q[k];
    end
  end

  AST_VEC_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq |-> (pend[vec] && ((pend & ((NUM_LINES'(1) << vec) - NUM_LINES'(1))) == '0))); // R5
  AST_MASKED_NEEDS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq && int'(vec) >= NUM_FIXED) |-> gie_q); // R6
  AST_ACK_CLEARS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> !gie_q); // R7
  AST_ACK_SAVES_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> (pgie_q == $past(gie_q))); // R7
  AST_RTI_RESTORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rti_i && !take) |=> (gie_q == $past(pgie_q))); // R8
endmodule

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
  import pic_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_evt = 0, nmi = 0, we = 0, ack = 0, rti = 0;
  logic [1:0]  rsv = '0;
  logic [3:0]  ext = '0;
  logic [11:0] per = '0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq_o;
  logic [3:0]  vec_o;

  prio_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rst_evt_i(rst_evt), .nmi_pin_i(nmi),
    .rsv_irq_i(rsv), .ext_pin_i(ext), .per_evt_i(per), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .ack_i(ack), .rti_i(rti), .irq_o(irq_o), .vec_o(vec_o)
  );

  int checks = 0, errors = 0;

  // behavioural reference model
  logic [15:0] m_flag = '0, m_ien = '0, m_prev = '0, m_src, m_set, m_clr, m_pool;
  logic        m_gie = 0, m_pgie = 0, m_irq;
  int          m_vec;
  int          m_sel [16];
  logic [3:0]  e_q = '0;
  int          e_cnt [4];
  logic        n_q = 0;
  int          n_cnt = 0;

  function automatic void m_pres(output logic irq, output int v);
    logic [15:0] p;
    p = m_flag & {(m_gie ? m_ien[15:4] : 12'h000), 4'hF};
    irq = 1'b0; v = 0;
    for (int i = 15; i >= 0; i--) if (p[i]) begin irq = 1'b1; v = i; end
  endfunction

  function automatic logic [31:0] m_rd(input logic [4:0] a);
    logic [31:0] r = '0;
    if (a == 0) r[15:0] = m_flag;
    if (a == 2) r[15:0] = {m_ien[15:4], 4'hF};
    if (a == 3) r[1:0] = {m_pgie, m_gie};
    if (a >= 20) r[3:0] = 4'(m_sel[a - 16]);
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_flag = '0; m_ien = '0; m_prev = '0; m_gie = 0; m_pgie = 0;
      e_q = '0; n_q = 0; n_cnt = 0;
      for (int k = 0; k < 16; k++) m_sel[k] = k - 4;
      for (int i = 0; i < 4; i++) e_cnt[i] = 0;
    end else begin
      m_pres(m_irq, m_vec);
      m_pool = {per, e_q};
      m_src[0] = rst_evt; m_src[1] = n_q; m_src[2] = rsv[0]; m_src[3] = rsv[1];
      for (int k = 4; k < 16; k++) m_src[k] = m_pool[m_sel[k]];
      for (int i = 0; i < 4; i++) begin
        if (ext[i] == e_q[i]) e_cnt[i] = 0;
        else if (e_cnt[i] == 3) begin e_q[i] = ext[i]; e_cnt[i] = 0; end
        else e_cnt[i]++;
      end
      if (nmi == n_q) n_cnt = 0;
      else if (n_cnt == 1) begin n_q = nmi; n_cnt = 0; end
      else n_cnt++;
      m_set = m_src & ~m_prev;
      m_prev = m_src;
      m_clr = '0;
      if (ack && m_irq) m_clr[m_vec] = 1'b1;
      if (we && addr == 1) m_clr = m_clr | wdata[15:0];
      m_flag = (m_flag & ~m_clr) | m_set;
      if (ack && m_irq) begin m_pgie = m_gie; m_gie = 0; end
      else if (rti) m_gie = m_pgie;
      else if (we && addr == 3) begin m_gie = wdata[0]; m_pgie = wdata[1]; end
      if (we && addr == 2) m_ien = {wdata[15:4], 4'h0};
      if (we && addr >= 20) m_sel[addr - 16] = int'(wdata[3:0]);
    end
  end

  // per-cycle comparison of the presented interrupt
  logic ei; int ev;
  always @(negedge clk) begin
    if (rst_n) begin
      m_pres(ei, ev);
      checks++;
      if (irq_o !== ei || (ei && int'(vec_o) != ev)) begin
        errors++;
        $display("FAIL R5/R6 irq_o/vec_o actual %0b/%0d expected %0b/%0d", irq_o, vec_o, ei, ev);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd_lit(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); addr = a; #1;
    checks++;
    if (rdata !== exp || rdata !== m_rd(a)) begin
      errors++;
      $display("FAIL %s addr %0d actual %h expected %h (model %h)", tag, a, rdata, exp, m_rd(a));
    end
  endtask

  task automatic chk_irq(input logic ei_x, input int ev_x, input string tag);
    checks++;
    if (irq_o !== ei_x || (ei_x && int'(vec_o) != ev_x)) begin
      errors++;
      $display("FAIL %s irq/vec actual %0b/%0d expected %0b/%0d", tag, irq_o, vec_o, ei_x, ev_x);
    end
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1; @(negedge clk); ack = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3); rst_n = 1;
    // R1 reset state and map
    chk_irq(0, 0, "R1");
    rd_lit(0, 0, "R1"); rd_lit(2, 32'hF, "R1"); rd_lit(3, 0, "R1");
    rd_lit(20, 0, "R1"); rd_lit(31, 11, "R1");
    // R2 edge set, level hold
    @(negedge clk); per[0] = 1; step(1);
    rd_lit(0, 32'h100, "R2"); chk_irq(0, 0, "R6");
    step(3);
    wr(1, 32'h100); rd_lit(0, 0, "R9"); step(3); rd_lit(0, 0, "R2");
    per[0] = 0; step(2); per[0] = 1; step(1); rd_lit(0, 32'h100, "R2");
    // R6 enables
    wr(2, 32'hFFFF); rd_lit(2, 32'hFFF0 | 32'hF, "R6"); chk_irq(0, 0, "R6");
    wr(3, 1); chk_irq(1, 8, "R6");
    // R5 priority
    @(negedge clk); per[1] = 1; rsv[0] = 1; step(1); chk_irq(1, 2, "R5");
    pulse_ack(); rd_lit(0, 32'h300, "R7"); rd_lit(3, 2, "R7"); chk_irq(0, 0, "R6");
    @(negedge clk); rti = 1; @(negedge clk); rti = 0;
    chk_irq(1, 8, "R8"); rd_lit(3, 3, "R8");
    pulse_ack(); rd_lit(0, 32'h200, "R7");
    wr(3, 0); pulse_ack(); rd_lit(0, 32'h200, "R7"); rd_lit(3, 0, "R7");
    per[1] = 0; per[0] = 0; rsv[0] = 0;
    wr(1, 32'hFFFF); rd_lit(0, 0, "R9");
    // R4 non-maskable pin
    @(negedge clk); nmi = 1; @(negedge clk); nmi = 0; step(4); rd_lit(0, 0, "R4");
    @(negedge clk); nmi = 1; step(2); nmi = 0; step(1);
    rd_lit(0, 32'h2, "R4"); chk_irq(1, 1, "R6");
    pulse_ack(); rd_lit(0, 0, "R7");
    // R3 external pin qualification
    @(negedge clk); ext[0] = 1; step(3); ext[0] = 0; step(6); rd_lit(0, 0, "R3");
    @(negedge clk); ext[0] = 1; step(5); rd_lit(0, 32'h10, "R3");
    wr(1, 32'h10); rd_lit(0, 0, "R9");
    @(negedge clk); ext[0] = 0; step(2); ext[0] = 1; step(8); rd_lit(0, 0, "R3");
    @(negedge clk); ext[0] = 0; step(4); ext[0] = 1; step(5); rd_lit(0, 32'h10, "R3");
    ext[0] = 0; step(6); wr(1, 32'hFFFF);
    // R10 selector
    wr(31, 15); wr(30, 15); rd_lit(31, 15, "R10");
    @(negedge clk); per[11] = 1; step(1); rd_lit(0, 32'hC000, "R10");
    @(negedge clk); per[6] = 1; step(2); rd_lit(0, 32'hC000, "R10");
    per[11] = 0; per[6] = 0; wr(1, 32'hFFFF); rd_lit(0, 0, "R9");
    // R11 collisions
    wr(3, 1);
    @(negedge clk); per[0] = 1; @(negedge clk); per[0] = 0; chk_irq(1, 8, "R11");
    @(negedge clk); ack = 1; rti = 1; per[0] = 1;
    @(negedge clk); ack = 0; rti = 0;
    rd_lit(0, 32'h100, "R11"); rd_lit(3, 2, "R11");
    @(negedge clk); per[0] = 0;
    @(negedge clk); we = 1; addr = 1; wdata = 32'h100; per[0] = 1;
    @(negedge clk); we = 0; rd_lit(0, 32'h100, "R11");
    wr(3, 1); chk_irq(1, 8, "R11");
    @(negedge clk); ack = 1; we = 1; addr = 3; wdata = 32'h3;
    @(negedge clk); ack = 0; we = 0; rd_lit(3, 2, "R11"); rd_lit(0, 0, "R7");
    // line 0 ignores masks
    @(negedge clk); rst_evt = 1; step(1); chk_irq(1, 0, "R6");
    rst_evt = 0; step(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule